// File: doc/BRIEF.md
# Scalar Multiplication Command Sequencer

This block is the control unit of an elliptic-curve scalar multiplication engine. A one-cycle start pulse hands it two inputs. The first is a scalar of `KW` bits. The second is a mode bit that picks the bit scan order. From these the block produces the exact stream of point-level commands that computes the scalar multiple. The commands are clear-to-infinity, doubling and addition. Each command names a destination register and a source register, where the accumulator Q is 0 and the base point P is 1. An external point-arithmetic unit executes the commands. The field arithmetic, the point storage and anything above the curve level are outside this block.

Each command is offered over a valid/ready handshake. The block then waits for a one-cycle completion pulse from the point unit before it offers the next command, so only one command is ever in flight. When the last command completes, the block raises a one-cycle done pulse. Two saturating counters report how many doublings and additions were accepted during the run.

Top module: `smul_sequencer`

## Requirements
- R1: After reset and after any reset during a run, `busy`, `cmdValid` and `doneOut` are 0, and both counters read 0.
- R2: Command opcodes are 2'b00 clear-to-infinity, 2'b01 doubling and 2'b10 addition. Register selects are 0 for Q and 1 for P. Every run begins with clear-to-infinity with destination Q and source Q.
- R3: With `modeIn`=0, the bits are scanned from bit KW-1 down to bit 0. Each bit gives a doubling (destination Q, source Q). When the bit is 1, an addition (destination Q, source P) follows.
- R4: With `modeIn`=1, the bits are scanned from bit 0 up to bit KW-1. When the bit is 1, an addition (destination Q, source P) comes first. Each bit then gives a doubling (destination P, source P).
- R5: A run issues exactly KW doublings and as many additions as the scalar has 1 bits.
- R6: While `cmdValid` is 1 and `cmdReady` is 0, `cmdValid` stays 1 and the opcode and selects stay unchanged.
- R7: After a command is accepted, `cmdValid` stays 0 until `unitDone` is seen. The next command is offered in the cycle after `unitDone`.
- R8: `doneOut` is high for exactly one cycle, the cycle after the `unitDone` of the last command. `busy` is high from the cycle after start through the `doneOut` cycle.
- R9: Each accepted doubling or addition raises its counter by one in the cycle after acceptance. A counter holds at 2^CW-1 instead of wrapping. Both counters read 0 in the cycle after `doneOut`.
- R10: A start pulse while `busy` is 1 has no effect on the command stream or the counts.
- R11: The scalar and mode are captured at start. Later changes on `scalarIn` or `modeIn` do not alter the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start pulse, taken only when idle |
| modeIn | input | 1 | Scan order: 0 = top bit first, 1 = bottom bit first |
| scalarIn | input | KW | Scalar multiplier |
| cmdValid | output | 1 | Command offered to the point unit |
| cmdReady | input | 1 | Point unit accepts the offered command |
| cmdOp | output | 2 | Command opcode |
| cmdDst | output | 1 | Destination register select |
| cmdSrc | output | 1 | Source register select |
| unitDone | input | 1 | Point unit finished the accepted command |
| busy | output | 1 | Run in progress |
| doneOut | output | 1 | One-cycle end-of-run pulse |
| dblCount | output | CW | Doublings accepted in this run, saturating |
| addCount | output | CW | Additions accepted in this run, saturating |

## Verification
Results are due at these offsets:
- The first command appears one cycle after the start edge.
- A counter changes one cycle after the accepting edge.
- `cmdValid` falls one cycle after the accepting edge.
- The next command, or `doneOut`, appears one cycle after the edge that samples `unitDone`.
- The counters clear one cycle after `doneOut`.

The bench drives all inputs on falling edges and samples outputs on the next falling edge, exactly one register stage later. It stretches the ready delay and the completion latency from command to command. The expected command trace, its length and the final counts are built from the scalar and mode alone.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    OP_SETINF = 2'b00,
    OP_DBL    = 2'b01,
    OP_ADD    = 2'b10
  } smulOp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } smulState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture scalar and mode, clear counters
    logic shift;   // advance to the next scalar bit
    logic incDbl;  // a doubling was accepted
    logic incAdd;  // an addition was accepted
    logic clrCnt;  // run finished, clear counters
  } smulStrobe_t;

endpackage

// File: rtl/smul_dpath.sv
module smul_dpath
  import smul_pkg::*;
#(
  parameter int KW = 256,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  smulStrobe_t   strobe,
  input  logic [KW-1:0] scalarIn,
  input  logic          modeIn,
  output logic          curBit,
  output logic          nextBit,
  output logic          lastBit,
  output logic          modeR,
  output logic [CW-1:0] dblCount,
  output logic [CW-1:0] addCount
);

  localparam int IW = $clog2(KW + 1);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [KW-1:0] shiftQ;
  logic [IW-1:0] remainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      remainQ <= '0;
      modeR   <= 1'b0;
    end else if (strobe.load) begin
      shiftQ  <= scalarIn;
      remainQ <= IW'(KW);
      modeR   <= modeIn;
    end else if (strobe.shift) begin
      shiftQ  <= modeR ? (shiftQ >> 1) : (shiftQ << 1);
      remainQ <= remainQ - 1'b1;
    end
  end

  assign curBit  = modeR ? shiftQ[0] : shiftQ[KW-1];
  assign nextBit = modeR ? shiftQ[1] : shiftQ[KW-2];
  assign lastBit = (remainQ == IW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dblCount <= '0;
      addCount <= '0;
    end else if (strobe.load || strobe.clrCnt) begin
      dblCount <= '0;
      addCount <= '0;
    end else begin
      if (strobe.incDbl && dblCount != CNT_MAX) dblCount <= dblCount + 1'b1;
      if (strobe.incAdd && addCount != CNT_MAX) addCount <= addCount + 1'b1;
    end
  end

  assert_dbl_sat_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dblCount == CNT_MAX && !strobe.clrCnt && !strobe.load) |=> dblCount == CNT_MAX);
  assert_add_sat_R9: assert property (@(posedge clk) disable iff (!rstN)
    (addCount == CNT_MAX && !strobe.clrCnt && !strobe.load) |=> addCount == CNT_MAX);
  assert_dbl_mono_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrCnt && !strobe.load) |=> dblCount >= $past(dblCount));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (dblCount == '0 && addCount == '0));

endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        cmdReady,
  input  logic        unitDone,
  input  logic        curBit,
  input  logic        nextBit,
  input  logic        lastBit,
  input  logic        modeR,
  output smulStrobe_t strobe,
  output logic        cmdValid,
  output logic [1:0]  cmdOp,
  output logic        cmdDst,
  output logic        cmdSrc,
  output logic        busy,
  output logic        doneOut
);

  smulState_e state, stateD;
  smulOp_e    opQ, opD;
  logic       advance;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= OP_SETINF;
    end else begin
      state <= stateD;
      opQ   <= opD;
    end
  end

  // a bit is finished after its last command completes
  assign advance = (!modeR && (opQ == OP_ADD || (opQ == OP_DBL && !curBit)))
                || ( modeR && opQ == OP_DBL);

  always_comb begin
    stateD = state;
    opD    = opQ;
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (startIn) begin
          strobe.load = 1'b1;
          opD         = OP_SETINF;
          stateD      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (cmdReady) begin
          stateD        = ST_WAIT;
          strobe.incDbl = (opQ == OP_DBL);
          strobe.incAdd = (opQ == OP_ADD);
        end
      end
      ST_WAIT: begin
        if (unitDone) begin
          if (advance) begin
            strobe.shift = 1'b1;
            if (lastBit) begin
              stateD = ST_FIN;
            end else begin
              stateD = ST_ISSUE;
              opD    = (modeR && nextBit) ? OP_ADD : OP_DBL;
            end
          end else begin
            stateD = ST_ISSUE;
            if (opQ == OP_SETINF) opD = (modeR && curBit) ? OP_ADD : OP_DBL;
            else if (opQ == OP_DBL) opD = OP_ADD;  // top-first, bit is 1
            else opD = OP_DBL;                     // bottom-first, after add
          end
        end
      end
      ST_FIN: begin
        strobe.clrCnt = 1'b1;
        stateD        = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign cmdValid = (state == ST_ISSUE);
  assign cmdOp    = opQ;
  assign cmdDst   = (opQ == OP_DBL) && modeR;
  assign cmdSrc   = (opQ == OP_ADD) || ((opQ == OP_DBL) && modeR);
  assign busy     = (state != ST_IDLE);
  assign doneOut  = (state == ST_FIN);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdOp) && $stable(cmdDst) && $stable(cmdSrc)));
  assert_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdValid);
  assert_wait_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && busy && !unitDone && !doneOut) |=> !cmdValid);
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> (!doneOut && !busy));
  assert_opcode_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdOp != 2'b11);
  assert_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (cmdOp == OP_SETINF && !cmdDst && !cmdSrc));

endmodule

// File: rtl/smul_sequencer.sv
module smul_sequencer
  import smul_pkg::*;
#(
  parameter int KW = 256,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startIn,
  input  logic          modeIn,
  input  logic [KW-1:0] scalarIn,
  output logic          cmdValid,
  input  logic          cmdReady,
  output logic [1:0]    cmdOp,
  output logic          cmdDst,
  output logic          cmdSrc,
  input  logic          unitDone,
  output logic          busy,
  output logic          doneOut,
  output logic [CW-1:0] dblCount,
  output logic [CW-1:0] addCount
);

  smulStrobe_t strobe;
  logic curBit, nextBit, lastBit, modeR;

  smul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .cmdReady (cmdReady),
    .unitDone (unitDone),
    .curBit   (curBit),
    .nextBit  (nextBit),
    .lastBit  (lastBit),
    .modeR    (modeR),
    .strobe   (strobe),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdDst   (cmdDst),
    .cmdSrc   (cmdSrc),
    .busy     (busy),
    .doneOut  (doneOut)
  );

  smul_dpath #(.KW(KW), .CW(CW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .scalarIn (scalarIn),
    .modeIn   (modeIn),
    .curBit   (curBit),
    .nextBit  (nextBit),
    .lastBit  (lastBit),
    .modeR    (modeR),
    .dblCount (dblCount),
    .addCount (addCount)
  );

endmodule

// File: tb/smul_sequencer_tb.sv
`timescale 1ns/1ps
module smul_sequencer_tb;

  localparam int KW  = 8;
  localparam int CW  = 8;
  localparam int CWS = 2;
  localparam int SATMAX = (1 << CWS) - 1;
  localparam int NV = 8;
  // {mode, scalar}
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'b1011_0010}, {1'b1, 8'b1011_0010}, {1'b0, 8'h00}, {1'b1, 8'hFF},
    {1'b0, 8'h80},        {1'b1, 8'h01},        {1'b0, 8'hFF}, {1'b1, 8'h5A}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0, modeIn = 1'b0, cmdReady = 1'b0, unitDone = 1'b0;
  logic [KW-1:0] scalarIn = '0;
  logic cmdValid, cmdDst, cmdSrc, busy, doneOut;
  logic [1:0] cmdOp;
  logic [CW-1:0] dblCount, addCount;
  logic sValid, sDst, sSrc, sBusy, sDone;
  logic [1:0] sOp;
  logic [CWS-1:0] sDbl, sAdd;

  int checkCount = 0;
  int failCount = 0;
  logic [1:0] eOp [2*KW+1];
  logic       eDst [2*KW+1];
  logic       eSrc [2*KW+1];
  int         eLen;

  always #2 clk = ~clk;

  smul_sequencer #(.KW(KW), .CW(CW)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .modeIn(modeIn), .scalarIn(scalarIn),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdDst(cmdDst), .cmdSrc(cmdSrc),
    .unitDone(unitDone), .busy(busy), .doneOut(doneOut), .dblCount(dblCount), .addCount(addCount));

  // narrow-counter copy in lockstep, for saturation
  smul_sequencer #(.KW(KW), .CW(CWS)) u_sat (
    .clk(clk), .rstN(rstN), .startIn(startIn), .modeIn(modeIn), .scalarIn(scalarIn),
    .cmdValid(sValid), .cmdReady(cmdReady), .cmdOp(sOp), .cmdDst(sDst), .cmdSrc(sSrc),
    .unitDone(unitDone), .busy(sBusy), .doneOut(sDone), .dblCount(sDbl), .addCount(sAdd));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic d, input logic s);
    eOp[eLen] = op; eDst[eLen] = d; eSrc[eLen] = s; eLen++;
  endtask

  task automatic buildTrace(input logic m, input logic [KW-1:0] k);
    eLen = 0;
    push(2'b00, 1'b0, 1'b0);
    if (!m) begin
      for (int i = KW - 1; i >= 0; i--) begin
        push(2'b01, 1'b0, 1'b0);
        if (k[i]) push(2'b10, 1'b0, 1'b1);
      end
    end else begin
      for (int i = 0; i < KW; i++) begin
        if (k[i]) push(2'b10, 1'b0, 1'b1);
        push(2'b01, 1'b1, 1'b1);
      end
    end
  endtask

  task automatic runOne(input logic m, input logic [KW-1:0] k, input bit disturb);
    int nDbl = 0;
    int nAdd = 0;
    string rq;
    rq = m ? "R4" : "R3";
    buildTrace(m, k);
    scalarIn = k; modeIn = m; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    if (disturb) begin scalarIn = ~k; modeIn = ~m; end  // R11
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
    for (int c = 0; c < eLen; c++) begin
      for (int w = 0; w < (c % 3); w++) begin
        check(cmdValid == 1'b1, "R6", "valid held", cmdValid, 1);
        check(cmdOp == eOp[c], "R6", "op held", cmdOp, eOp[c]);
        if (disturb && c == 1) startIn = 1'b1;  // R10
        @(negedge clk);
        startIn = 1'b0;
      end
      check(cmdValid == 1'b1, "R7", "valid offered", cmdValid, 1);
      check(cmdOp == eOp[c], (c == 0) ? "R2" : rq, "opcode", cmdOp, eOp[c]);
      check(cmdDst == eDst[c], (c == 0) ? "R2" : rq, "dst", cmdDst, eDst[c]);
      check(cmdSrc == eSrc[c], (c == 0) ? "R2" : rq, "src", cmdSrc, eSrc[c]);
      cmdReady = 1'b1;
      @(negedge clk);
      cmdReady = 1'b0;
      if (eOp[c] == 2'b01) nDbl++;
      if (eOp[c] == 2'b10) nAdd++;
      check(cmdValid == 1'b0, "R7", "valid after accept", cmdValid, 0);
      check(dblCount == CW'(nDbl), "R9", "dbl running", dblCount, nDbl);
      check(addCount == CW'(nAdd), "R9", "add running", addCount, nAdd);
      for (int w = 0; w < (c % 2); w++) begin
        @(negedge clk);
        check(cmdValid == 1'b0, "R7", "valid while waiting", cmdValid, 0);
      end
      unitDone = 1'b1;
      @(negedge clk);
      unitDone = 1'b0;
      if (c < eLen - 1)
        check(doneOut == 1'b0, "R8", "no early done", doneOut, 0);
    end
    check(doneOut == 1'b1, "R8", "done pulse", doneOut, 1);
    check(dblCount == CW'(KW), "R5", "dbl total", dblCount, KW);
    check(addCount == CW'($countones(k)), "R5", "add total", addCount, $countones(k));
    check(sDbl == CWS'(SATMAX), "R9", "dbl saturates", sDbl, SATMAX);
    check(int'(sAdd) == (($countones(k) > SATMAX) ? SATMAX : $countones(k)), "R9", "add saturates",
          sAdd, ($countones(k) > SATMAX) ? SATMAX : $countones(k));
    @(negedge clk);
    check(doneOut == 1'b0, "R8", "done one cycle", doneOut, 0);
    check(busy == 1'b0, "R10", "idle after run", busy, 0);
    check(dblCount == '0 && addCount == '0, "R9", "counts cleared", dblCount + addCount, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && cmdValid == 1'b0 && doneOut == 1'b0, "R1", "reset outputs", busy, 0);
    check(dblCount == '0 && addCount == '0, "R1", "reset counts", dblCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) runOne(VEC[v][8], VEC[v][KW-1:0], 1'b0);
    // captured scalar and ignored start during run (R10, R11)
    runOne(1'b0, 8'b0110_1001, 1'b1);
    runOne(1'b1, 8'b1100_0101, 1'b1);
    // reset in the middle of a run (R1)
    scalarIn = 8'hC3; modeIn = 1'b0; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0; cmdReady = 1'b1;
    repeat (3) @(negedge clk);
    cmdReady = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && cmdValid == 1'b0, "R1", "reset mid run", busy, 0);
    check(dblCount == '0, "R1", "reset mid run count", dblCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    runOne(1'b1, 8'h81, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule